// File: doc/BRIEF.md
# Four-Event Input Capture Timer

This block measures the timing of edges on a single capture input. A free-running up-counter provides the time base. Four capture slots are filled in turn by a 2-bit event pointer. Each slot has its own edge polarity. Each slot can also clear the counter right after its capture, so every slot can record either an absolute time-stamp or the time elapsed since the previous event.

The capture input passes through a two-flop synchroniser. An optional divider then counts rising edges of the synchronised input and produces a slower square wave, and the slot polarity is applied to that wave. The pointer can run continuously, wrapping from the fourth slot back to the first. It can also stop after a chosen slot, in which case capture stays off until a re-arm strobe restarts it at the first slot.

Each slot has a sticky event flag, and so does counter overflow. An interrupt output combines the flags whose enables are set. All configuration comes from static control inputs. The counter width is a parameter with a default of 32 bits.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the counter, all capture slots, the flags and the event pointer are zero. The counter increases by one on every clock while `run_en` is 1 and holds its value while `run_en` is 0.
- R2: When the counter is at its all-ones value and `run_en` is 1, the next value is zero and flag bit 4 (overflow) is set. This also applies when a counter clear from a capture falls in the same cycle.
- R3: A qualified event writes the current counter value into the slot named by `evt_idx`. In the same clock, `evt_idx` moves to the next slot.
- R4: `edge_pol[i]` selects the qualifying edge for slot i: 0 means a rising edge and 1 means a falling edge. An edge of the other kind is ignored while slot i is current.
- R5: When `delta_rst[i]` is 1, a capture into slot i loads the counter with zero, so the next capture holds the event spacing minus one. When `delta_rst[i]` is 0, the counter keeps running, and the difference between consecutive slots equals the event spacing in clocks.
- R6: Code 0 on `prescale` bypasses the divider. Codes 1 to 5 toggle the divided signal every 1 to 5 rising input edges, which divides by 2, 4, 6, 8 and 10. Codes 6 and 7 behave as code 5.
- R7: When `oneshot` is 0, the pointer wraps from slot 3 to slot 0, and later events overwrite the older slots.
- R8: When `oneshot` is 1, after capturing into the slot equal to `stop_sel`, the pointer still advances but capture stops. Further edges change neither the slots nor the event flags.
- R9: A one-cycle `rearm` pulse sets `evt_idx` to 0 and re-enables capture. It takes priority over an event in the same cycle.
- R10: Flag bits 0 to 3 are set by captures into slots 0 to 3 and stay set until cleared. A 1 on a bit of `flag_clr` clears that flag bit; a set in the same cycle wins. `irq` is 1 whenever any flag bit is 1 together with the matching bit of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Asynchronous capture input |
| run_en | input | 1 | 1 lets the counter run, 0 freezes it |
| oneshot | input | 1 | 0 continuous, 1 stop after slot `stop_sel` |
| stop_sel | input | 2 | Last slot captured in one-shot operation |
| rearm | input | 1 | Pulse: restart at slot 0 and enable capture |
| prescale | input | 3 | Input divider code |
| edge_pol | input | 4 | Per-slot edge select, 1 = falling |
| delta_rst | input | 4 | Per-slot counter clear after capture |
| irq_en | input | 5 | Interrupt enables, bit 4 = overflow |
| flag_clr | input | 5 | Write-one-to-clear for the flags |
| count | output | CNT_W | Time-base counter value |
| cap_regs | output | 4 x CNT_W | Capture slots, slot i in element i |
| evt_idx | output | 2 | Slot that the next event will fill |
| flags | output | 5 | Sticky flags, bits 0-3 slots, bit 4 overflow |
| irq | output | 1 | Interrupt request |

## Verification
In bypass mode, an input change driven before clock edge k is stored in a slot, and sets its flag, at edge k+2 or k+3. The divider adds one more clock. The counter steps on every edge, and `irq` follows the flags without delay. Because the input latency is constant, the bench checks slot contents as differences between slots, or as the spacing minus one after a counter clear, rather than as absolute times. The bench waits at least eight clocks after the last input change before it compares slots or flags, and it samples on the falling clock edge. Counter checks compare two samples taken a known number of edges apart.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int NSLOT   = 4;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int PRE_W   = 3;
    localparam int NFLAG   = NSLOT + 1;
    localparam int OVF_BIT = NSLOT;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // number of rising input edges between toggles of the divided signal; 0 = bypass
    function automatic logic [PRE_W-1:0] toggle_count(input logic [PRE_W-1:0] code);
        return (code > 3'd5) ? 3'd5 : code;
    endfunction
endpackage

// File: rtl/cap_input_cond.sv
module cap_input_cond
    import cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_in,
    input  logic [PRE_W-1:0] prescale,
    output edge_t            ev
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   s_now, s_prev;
    logic [PRE_W-1:0]       half, div_cnt;
    logic                   div_q, div_prev, bypass, sig, sig_d, in_rise;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
    end

    assign s_now   = sync_q[SYNC_STAGES-1];
    assign half    = toggle_count(prescale);
    assign bypass  = (half == '0);
    assign in_rise = s_now & ~s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_prev   <= 1'b0;
            div_cnt  <= '0;
            div_q    <= 1'b0;
            div_prev <= 1'b0;
        end else begin
            s_prev   <= s_now;
            div_prev <= div_q;
            if (bypass) begin
                div_cnt <= '0;
                div_q   <= 1'b0;
            end else if (in_rise) begin
                if (div_cnt == half - 3'd1) begin
                    div_cnt <= '0;
                    div_q   <= ~div_q;
                end else begin
                    div_cnt <= div_cnt + 3'd1;
                end
            end
        end
    end

    assign sig     = bypass ? s_now  : div_q;
    assign sig_d   = bypass ? s_prev : div_prev;
    assign ev.rise = sig & ~sig_d;
    assign ev.fall = ~sig & sig_d;
endmodule

// File: rtl/cap_ts_counter.sv
module cap_ts_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             clr_req,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = run_en & (&count);

    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (clr_req) count <= '0;
        else if (run_en)  count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/cap_sequencer.sv
module cap_sequencer
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  edge_t                       ev,
    input  logic [NSLOT-1:0]            edge_pol,
    input  logic [NSLOT-1:0]            delta_rst,
    input  logic                        oneshot,
    input  slot_t                       stop_sel,
    input  logic                        rearm,
    input  logic [CNT_W-1:0]            count,
    output logic [NSLOT-1:0][CNT_W-1:0] cap_regs,
    output slot_t                       evt_idx,
    output logic                        armed,
    output logic                        cap_fire,
    output logic                        cnt_clr,
    output logic [NSLOT-1:0]            evt_set
);
    logic want;

    assign want     = edge_pol[evt_idx] ? ev.fall : ev.rise;
    assign cap_fire = armed & want & ~rearm;
    assign cnt_clr  = cap_fire & delta_rst[evt_idx];
    assign evt_set  = cap_fire ? (NSLOT'(1) << evt_idx) : '0;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)             cap_regs[g] <= '0;
            else if (evt_set[g]) cap_regs[g] <= count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_idx <= '0;
            armed   <= 1'b1;
        end else if (rearm) begin
            evt_idx <= '0;
            armed   <= 1'b1;
        end else if (cap_fire) begin
            evt_idx <= evt_idx + 1'b1;
            if (oneshot && evt_idx == stop_sel) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cap_in,
    input  logic                        run_en,
    input  logic                        oneshot,
    input  logic [SLOT_W-1:0]           stop_sel,
    input  logic                        rearm,
    input  logic [PRE_W-1:0]            prescale,
    input  logic [NSLOT-1:0]            edge_pol,
    input  logic [NSLOT-1:0]            delta_rst,
    input  logic [NFLAG-1:0]            irq_en,
    input  logic [NFLAG-1:0]            flag_clr,
    output logic [CNT_W-1:0]            count,
    output logic [NSLOT-1:0][CNT_W-1:0] cap_regs,
    output logic [SLOT_W-1:0]           evt_idx,
    output logic [NFLAG-1:0]            flags,
    output logic                        irq
);
    edge_t            ev;
    logic             wrap, cap_fire, cnt_clr, armed;
    logic [NSLOT-1:0] evt_set;

    cap_input_cond #(.SYNC_STAGES(2)) u_cond (
        .clk(clk), .rst(rst), .cap_in(cap_in), .prescale(prescale), .ev(ev)
    );

    cap_ts_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .run_en(run_en), .clr_req(cnt_clr),
        .count(count), .wrap(wrap)
    );

    cap_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .ev(ev), .edge_pol(edge_pol), .delta_rst(delta_rst),
        .oneshot(oneshot), .stop_sel(stop_sel), .rearm(rearm), .count(count),
        .cap_regs(cap_regs), .evt_idx(evt_idx), .armed(armed),
        .cap_fire(cap_fire), .cnt_clr(cnt_clr), .evt_set(evt_set)
    );

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~flag_clr) | {wrap, evt_set};
    end

    assign irq = |(flags & irq_en);
endmodule

// File: rtl/edge_capture_timer_chk.sv
module edge_capture_timer_chk
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        run_en,
    input logic                        oneshot,
    input logic [SLOT_W-1:0]           stop_sel,
    input logic                        rearm,
    input logic [CNT_W-1:0]            count,
    input logic [NSLOT-1:0][CNT_W-1:0] cap_regs,
    input logic [SLOT_W-1:0]           evt_idx,
    input logic [NFLAG-1:0]            flags,
    input logic                        cap_fire,
    input logic                        cnt_clr,
    input logic                        armed
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run_en && !cnt_clr && !(&count)) |=> count == $past(count) + CNT_W'(1)); // R1
    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !cnt_clr) |=> $stable(count)); // R1
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (run_en && (&count)) |=> (count == '0 && flags[OVF_BIT])); // R2
    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> cap_regs[$past(evt_idx)] == $past(count)); // R3
    AST_DELTA_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> count == '0); // R5
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> evt_idx == $past(evt_idx) + 1'b1); // R7
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (cap_fire && oneshot && evt_idx == stop_sel) |=> !armed); // R8
    AST_REARM: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (evt_idx == '0 && armed)); // R9
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> flags[$past(evt_idx)]); // R10
endmodule

bind edge_capture_timer edge_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .oneshot(oneshot), .stop_sel(stop_sel),
    .rearm(rearm), .count(count), .cap_regs(cap_regs), .evt_idx(evt_idx),
    .flags(flags), .cap_fire(cap_fire), .cnt_clr(cnt_clr), .armed(armed)
);

// File: tb/edge_capture_timer_bench.sv
module edge_capture_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct packed {
        logic [2:0] pre;
        logic [3:0] pol;
        logic [3:0] dlt;
        logic [7:0] hi;
        logic [7:0] per;
        logic [7:0] e0;
        logic [7:0] e1;
        logic [7:0] e2;
    } row_t;

    localparam int NROWS = 8;
    localparam row_t ROWS [NROWS] = '{
        '{3'd0, 4'b0000, 4'b0000, 8'd5, 8'd16, 8'd16, 8'd16, 8'd16},
        '{3'd0, 4'b1111, 4'b0000, 8'd5, 8'd16, 8'd16, 8'd16, 8'd16},
        '{3'd0, 4'b1010, 4'b0000, 8'd7, 8'd20, 8'd7,  8'd13, 8'd7 },
        '{3'd0, 4'b0000, 4'b1111, 8'd5, 8'd16, 8'd16, 8'd16, 8'd16},
        '{3'd0, 4'b0101, 4'b0110, 8'd4, 8'd12, 8'd8,  8'd4,  8'd8 },
        '{3'd1, 4'b0000, 4'b0000, 8'd5, 8'd12, 8'd24, 8'd24, 8'd24},
        '{3'd2, 4'b0000, 4'b0010, 8'd5, 8'd10, 8'd40, 8'd40, 8'd40},
        '{3'd1, 4'b1111, 4'b0000, 8'd3, 8'd14, 8'd28, 8'd28, 8'd28}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cap_in = 1'b0, run_en = 1'b1, oneshot = 1'b0, rearm = 1'b0;
    logic [1:0] stop_sel = 2'd3;
    logic [2:0] prescale = 3'd0;
    logic [3:0] edge_pol = '0, delta_rst = '0;
    logic [4:0] irq_en = '0, flag_clr = '0;
    logic [W-1:0] count;
    logic [3:0][W-1:0] cap_regs;
    logic [1:0] evt_idx;
    logic [4:0] flags;
    logic irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_capture_timer #(.CNT_W(W)) u_edge_capture_timer (
        .clk(clk), .rst(rst), .cap_in(cap_in), .run_en(run_en), .oneshot(oneshot),
        .stop_sel(stop_sel), .rearm(rearm), .prescale(prescale), .edge_pol(edge_pol),
        .delta_rst(delta_rst), .irq_en(irq_en), .flag_clr(flag_clr), .count(count),
        .cap_regs(cap_regs), .evt_idx(evt_idx), .flags(flags), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic pulses(input int n, input int hi, input int per);
        for (int i = 0; i < n; i++) begin
            cap_in = 1'b1;
            idle(hi);
            cap_in = 1'b0;
            idle(per - hi);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] t0, ob, old0;
        logic [7:0] expv [3];

        // reset state, R1
        idle(3);
        chk("R1 reset count", 32'(count), 0);
        chk("R1 reset slots", 32'(cap_regs), 0);
        chk("R1 reset flags", 32'(flags), 0);
        chk("R1 reset evt_idx", 32'(evt_idx), 0);
        chk("R10 reset irq", 32'(irq), 0);

        // table walk: R3 R4 R5 R6, one-shot capture of four events
        for (int r = 0; r < NROWS; r++) begin
            oneshot = 1'b1; stop_sel = 2'd3; run_en = 1'b1;
            prescale = ROWS[r].pre; edge_pol = ROWS[r].pol; delta_rst = ROWS[r].dlt;
            do_reset();
            pulses(18, int'(ROWS[r].hi), int'(ROWS[r].per));
            idle(8);
            expv[0] = ROWS[r].e0; expv[1] = ROWS[r].e1; expv[2] = ROWS[r].e2;
            for (int i = 0; i < 3; i++) begin
                if (ROWS[r].dlt[i]) ob = cap_regs[i+1] + W'(1);
                else                ob = cap_regs[i+1] - cap_regs[i];
                chk($sformatf("R3/R4/R5/R6 row %0d spacing %0d", r, i), 32'(ob), 32'(expv[i]));
            end
            chk($sformatf("R3 row %0d flags", r), 32'(flags[3:0]), 32'hF);
        end

        // R1 run and freeze
        prescale = 3'd0; edge_pol = '0; delta_rst = '0; oneshot = 1'b0;
        do_reset();
        idle(4);
        t0 = count;
        idle(10);
        chk("R1 count step", 32'(W'(count - t0)), 10);
        run_en = 1'b0;
        idle(1);
        t0 = count;
        idle(10);
        chk("R1 freeze", 32'(count), 32'(t0));
        run_en = 1'b1;

        // R2 overflow with W-bit counter
        do_reset();
        irq_en = 5'b10000;
        idle(200);
        chk("R2 no early overflow", 32'(flags[4]), 0);
        chk("R10 irq idle", 32'(irq), 0);
        idle(70);
        chk("R2 overflow flag", 32'(flags[4]), 1);
        chk("R10 irq on overflow", 32'(irq), 1);
        irq_en = 5'b00000;
        #1;
        chk("R10 irq masked", 32'(irq), 0);
        flag_clr = 5'b10000;
        idle(1);
        flag_clr = '0;
        chk("R10 overflow cleared", 32'(flags[4]), 0);

        // R7 continuous wrap
        oneshot = 1'b0;
        do_reset();
        pulses(6, 5, 16);
        idle(8);
        chk("R7 pointer wrapped", 32'(evt_idx), 2);
        chk("R7 slot1-slot0", 32'(W'(cap_regs[1] - cap_regs[0])), 16);
        chk("R7 slot0-slot3", 32'(W'(cap_regs[0] - cap_regs[3])), 16);
        chk("R7 flags", 32'(flags[3:0]), 32'hF);

        // R10 per-event irq and W1C
        irq_en = 5'b00100;
        #1;
        chk("R10 irq event 2", 32'(irq), 1);
        flag_clr = 5'b00100;
        idle(1);
        flag_clr = '0;
        chk("R10 flag2 cleared", 32'(flags[2]), 0);
        chk("R10 irq after clear", 32'(irq), 0);
        irq_en = '0;

        // R8 one-shot stop at slot 1, R9 re-arm
        oneshot = 1'b1; stop_sel = 2'd1;
        do_reset();
        pulses(6, 5, 16);
        idle(8);
        chk("R8 stopped pointer", 32'(evt_idx), 2);
        chk("R8 slot2 untouched", 32'(cap_regs[2]), 0);
        chk("R8 slot3 untouched", 32'(cap_regs[3]), 0);
        chk("R8 flags", 32'(flags[3:0]), 32'h3);
        old0 = cap_regs[0];
        rearm = 1'b1;
        idle(1);
        rearm = 1'b0;
        chk("R9 rearm pointer", 32'(evt_idx), 0);
        pulses(1, 5, 16);
        idle(8);
        chk("R9 capture resumed", 32'(evt_idx), 1);
        chk("R9 slot0 refreshed", 32'(cap_regs[0] != old0), 1);

        finish_run();
    end
endmodule